// File: doc/BRIEF.md
# Load Address Hold Buffer

This block sits beside the data cache of a processor that runs two redundant copies of one program, a leading copy and a trailing copy. A cached load by the trailing copy must return the same value the leading copy saw. The block therefore remembers every cache-block address that the leading copy has loaded and the trailing copy has not yet re-loaded. While any such load is outstanding, it stops the cache from evicting or invalidating that block.

Each tracked address has one entry with an outstanding-load counter. A leading load either claims a free entry or adds one to the counter of the entry that already holds its address. A retiring trailing load subtracts one. The cache controller presents a block address when it wants to replace or invalidate a block, and in the same cycle the block answers allow or defer. A deferred request is remembered as pending on the entry. When that entry's counter later drains to zero, the block emits a one-cycle completion pulse carrying the address, and the entry becomes free again.

Top module: `loadHoldBuffer`

## Requirements
- R1: After reset no address is tracked: `leadStall`, `invDone`, `evictAllow` and `evictDefer` are low, and an eviction request for any address is allowed.
- R2: A leading load to an untracked address, when a free entry exists, is accepted (`leadStall` low) and tracked with one outstanding load.
- R3: Further leading loads to a tracked address add one each, and that many trailing retires are needed before the count reaches zero.
- R4: An eviction request is answered combinationally in the same cycle. It gets `evictAllow`=1 and `evictDefer`=0 when no in-use entry holds the address, or when the matching count is zero. Both outputs are low when no request is present.
- R5: An eviction request that matches an entry with a nonzero count gets `evictDefer`=1 and `evictAllow`=0, and marks that entry pending.
- R6: When a pending entry's count reaches zero through a trailing retire, `invDone` is high for exactly one cycle, in the cycle after that retire, with `invDoneAddr` equal to the address. The entry is then free.
- R7: When every entry is in use, a leading load to an untracked address raises `leadStall` in the same cycle and is not recorded. A leading load to a tracked address is still accepted.
- R8: An entry whose count is zero and whose pending flag is clear is free, and a later leading load to a new address can claim it.
- R9: A leading load and a trailing retire that hit the same entry in the same cycle leave its count unchanged.
- R10: A leading load to an entry whose count is at its maximum (all ones in `CNT_W` bits) raises `leadStall` and does not change the count.
- R11: A trailing retire to an untracked address has no effect.
- R12: No two in-use entries ever hold the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| leadValid | input | 1 | Leading-copy cached load presented this cycle |
| leadAddr | input | ADDR_W | Block address of the leading load |
| leadStall | output | 1 | Leading load not accepted this cycle |
| trailValid | input | 1 | Trailing-copy load retiring this cycle |
| trailAddr | input | ADDR_W | Block address of the retiring trailing load |
| evictReq | input | 1 | Cache asks to replace or invalidate a block |
| evictAddr | input | ADDR_W | Block address of that request |
| evictAllow | output | 1 | Request may proceed now |
| evictDefer | output | 1 | Request refused and recorded as pending |
| invDone | output | 1 | One-cycle pulse: a pending invalidation may complete |
| invDoneAddr | output | ADDR_W | Address that goes with `invDone` |

## Verification
On every cycle the embedded assertions check several invariants. At most one in-use entry matches an address. A full counter never wraps to zero, and a counter at zero never jumps by more than one. A pending flag survives while its count is above one. A completion pulse only follows a trailing retire. The scenarios are needed to show the externally visible orderings: a deferral turning into exactly one completion pulse in the right cycle, a simultaneous hit and retire leaving the count alone, stalls on a full buffer or a saturated counter, and reuse of a drained entry. Each of these is shown through the allow or defer answer to a later eviction request.

// File: rtl/lhbPkg.sv
`timescale 1ns/1ps
package lhbPkg;
  // Strobes from control to the entry array for one cycle.
  typedef struct packed {
    logic alloc;    // claim the first free entry for the leading address
    logic inc;      // add one to the entry matching the leading address
    logic dec;      // subtract one from the entry matching the trailing address
    logic setPend;  // mark the entry matching the eviction address pending
    logic drain;    // clear pending on the trailing entry (count hits zero)
  } lhbStrobe_t;
endpackage

// File: rtl/lhbDatapath.sv
`timescale 1ns/1ps
module lhbDatapath
  import lhbPkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 26,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] leadAddr,
  input  logic [ADDR_W-1:0] trailAddr,
  input  logic [ADDR_W-1:0] evictAddr,
  input  lhbStrobe_t        strobe,
  output logic              leadHit,
  output logic              leadCntMax,
  output logic              freeAny,
  output logic              trailHit,
  output logic              trailCntOne,
  output logic              trailPend,
  output logic              leadTrailSame,
  output logic              evictHit,
  output logic              evictCntNz,
  output logic              evictTrailSame
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] addrQ [ENTRIES];
  logic [CNT_W-1:0]  cntQ  [ENTRIES];
  logic [ENTRIES-1:0] pendQ;

  logic [ENTRIES-1:0] inUse, leadHitVec, trailHitVec, evictHitVec;
  logic [IDX_W-1:0]   leadIdx, trailIdx, evictIdx, freeIdx;

  function automatic logic [IDX_W-1:0] firstSet(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (v[k]) r = IDX_W'(k);
    end
    return r;
  endfunction

  // Associative compare against every in-use entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign inUse[g]       = (cntQ[g] != '0) || pendQ[g];
    assign leadHitVec[g]  = inUse[g] && (addrQ[g] == leadAddr);
    assign trailHitVec[g] = inUse[g] && (addrQ[g] == trailAddr);
    assign evictHitVec[g] = inUse[g] && (addrQ[g] == evictAddr);
  end

  always_comb begin
    leadIdx  = firstSet(leadHitVec);
    trailIdx = firstSet(trailHitVec);
    evictIdx = firstSet(evictHitVec);
    freeIdx  = firstSet(~inUse);
  end

  assign leadHit        = |leadHitVec;
  assign trailHit       = |trailHitVec;
  assign evictHit       = |evictHitVec;
  assign freeAny        = ~&inUse;
  assign leadCntMax     = cntQ[leadIdx] == CNT_MAX;
  assign trailCntOne    = cntQ[trailIdx] == CNT_ONE;
  assign trailPend      = pendQ[trailIdx];
  assign evictCntNz     = cntQ[evictIdx] != '0;
  assign leadTrailSame  = leadHit && trailHit && (leadIdx == trailIdx);
  assign evictTrailSame = evictHit && trailHit && (evictIdx == trailIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        addrQ[i] <= '0;
        cntQ[i]  <= '0;
      end
      pendQ <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        logic incE, decE;
        incE = strobe.inc && (leadIdx == IDX_W'(i));
        decE = strobe.dec && (trailIdx == IDX_W'(i));
        if (strobe.alloc && (freeIdx == IDX_W'(i))) begin
          addrQ[i] <= leadAddr;
          cntQ[i]  <= CNT_ONE;
          pendQ[i] <= 1'b0;
        end else begin
          if (incE && !decE) cntQ[i] <= cntQ[i] + CNT_ONE;
          else if (decE && !incE) cntQ[i] <= cntQ[i] - CNT_ONE;
          if (strobe.drain && (trailIdx == IDX_W'(i))) pendQ[i] <= 1'b0;
          else if (strobe.setPend && (evictIdx == IDX_W'(i))) pendQ[i] <= 1'b1;
        end
      end
    end
  end

  // R12
  uniq_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(leadHitVec));

  for (genvar g = 0; g < ENTRIES; g++) begin : gChk
    // R10
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ[g] == CNT_MAX) |=> (cntQ[g] != '0));
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ[g] == '0) |=> (cntQ[g] <= CNT_ONE));
    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pendQ[g] && (cntQ[g] > CNT_ONE)) |=> pendQ[g]);
  end
endmodule

// File: rtl/lhbControl.sv
`timescale 1ns/1ps
module lhbControl
  import lhbPkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              leadValid,
  input  logic              trailValid,
  input  logic [ADDR_W-1:0] trailAddr,
  input  logic              evictReq,
  input  logic              leadHit,
  input  logic              leadCntMax,
  input  logic              freeAny,
  input  logic              trailHit,
  input  logic              trailCntOne,
  input  logic              trailPend,
  input  logic              leadTrailSame,
  input  logic              evictHit,
  input  logic              evictCntNz,
  input  logic              evictTrailSame,
  output lhbStrobe_t        strobe,
  output logic              leadStall,
  output logic              evictAllow,
  output logic              evictDefer,
  output logic              invDone,
  output logic [ADDR_W-1:0] invDoneAddr
);
  logic refuse, reachZero, pendAfter;

  assign refuse = evictReq && evictHit && evictCntNz;

  always_comb begin
    strobe         = '0;
    strobe.inc     = leadValid && leadHit && !leadCntMax;
    strobe.alloc   = leadValid && !leadHit && freeAny;
    strobe.dec     = trailValid && trailHit;
    strobe.setPend = refuse;
    reachZero      = strobe.dec && trailCntOne && !(strobe.inc && leadTrailSame);
    pendAfter      = trailPend || (refuse && evictTrailSame);
    strobe.drain   = reachZero && pendAfter;
  end

  assign leadStall  = leadValid && (leadHit ? leadCntMax : !freeAny);
  assign evictAllow = evictReq && !refuse;
  assign evictDefer = refuse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      invDone     <= 1'b0;
      invDoneAddr <= '0;
    end else begin
      invDone     <= strobe.drain;
      invDoneAddr <= strobe.drain ? trailAddr : invDoneAddr;
    end
  end

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    invDone |-> $past(trailValid));
  // R4
  answer_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(evictAllow && evictDefer));
endmodule

// File: rtl/loadHoldBuffer.sv
`timescale 1ns/1ps
module loadHoldBuffer
  import lhbPkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 26,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              leadValid,
  input  logic [ADDR_W-1:0] leadAddr,
  output logic              leadStall,
  input  logic              trailValid,
  input  logic [ADDR_W-1:0] trailAddr,
  input  logic              evictReq,
  input  logic [ADDR_W-1:0] evictAddr,
  output logic              evictAllow,
  output logic              evictDefer,
  output logic              invDone,
  output logic [ADDR_W-1:0] invDoneAddr
);
  lhbStrobe_t strobe;
  logic leadHit, leadCntMax, freeAny, trailHit, trailCntOne, trailPend;
  logic leadTrailSame, evictHit, evictCntNz, evictTrailSame;

  lhbDatapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN),
    .leadAddr(leadAddr), .trailAddr(trailAddr), .evictAddr(evictAddr),
    .strobe(strobe),
    .leadHit(leadHit), .leadCntMax(leadCntMax), .freeAny(freeAny),
    .trailHit(trailHit), .trailCntOne(trailCntOne), .trailPend(trailPend),
    .leadTrailSame(leadTrailSame), .evictHit(evictHit),
    .evictCntNz(evictCntNz), .evictTrailSame(evictTrailSame)
  );

  lhbControl #(.ADDR_W(ADDR_W)) uCtl (
    .clk(clk), .rstN(rstN),
    .leadValid(leadValid), .trailValid(trailValid), .trailAddr(trailAddr),
    .evictReq(evictReq),
    .leadHit(leadHit), .leadCntMax(leadCntMax), .freeAny(freeAny),
    .trailHit(trailHit), .trailCntOne(trailCntOne), .trailPend(trailPend),
    .leadTrailSame(leadTrailSame), .evictHit(evictHit),
    .evictCntNz(evictCntNz), .evictTrailSame(evictTrailSame),
    .strobe(strobe),
    .leadStall(leadStall), .evictAllow(evictAllow), .evictDefer(evictDefer),
    .invDone(invDone), .invDoneAddr(invDoneAddr)
  );
endmodule

// File: tb/sim_loadHoldBuffer.sv
`timescale 1ns/1ps
module sim_loadHoldBuffer;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic leadValid = 1'b0, trailValid = 1'b0, evictReq = 1'b0;
  logic [AW-1:0] leadAddr = '0, trailAddr = '0, evictAddr = '0;
  logic leadStall, evictAllow, evictDefer, invDone;
  logic [AW-1:0] invDoneAddr;

  always #2 clk = ~clk;

  loadHoldBuffer #(.ENTRIES(4), .ADDR_W(AW), .CNT_W(2)) u0 (
    .clk(clk), .rstN(rstN),
    .leadValid(leadValid), .leadAddr(leadAddr), .leadStall(leadStall),
    .trailValid(trailValid), .trailAddr(trailAddr),
    .evictReq(evictReq), .evictAddr(evictAddr),
    .evictAllow(evictAllow), .evictDefer(evictDefer),
    .invDone(invDone), .invDoneAddr(invDoneAddr)
  );

  typedef struct packed {
    logic allow; logic defer; logic stall; logic done; logic [AW-1:0] doneAddr;
  } expect_t;

  expect_t expQ[$];
  string   tagQ[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Driver: one call per cycle, expected outputs for that same cycle.
  task automatic step(input logic lv, input logic [AW-1:0] la,
                      input logic tv, input logic [AW-1:0] ta,
                      input logic ev, input logic [AW-1:0] ea,
                      input logic eAllow, input logic eDefer, input logic eStall,
                      input logic eDone, input logic [AW-1:0] eDoneAddr,
                      input string tag);
    expect_t e;
    @(negedge clk);
    leadValid = lv; leadAddr = la;
    trailValid = tv; trailAddr = ta;
    evictReq = ev; evictAddr = ea;
    e.allow = eAllow; e.defer = eDefer; e.stall = eStall;
    e.done = eDone; e.doneAddr = eDoneAddr;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input logic eDone, input logic [AW-1:0] eDoneAddr, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, eDone, eDoneAddr, tag);
  endtask

  task automatic lead(input logic [AW-1:0] a, input logic eStall, input string tag);
    step(1, a, 0, 0, 0, 0, 0, 0, eStall, 0, 0, tag);
  endtask

  task automatic trail(input logic [AW-1:0] a, input string tag);
    step(0, 0, 1, a, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic evict(input logic [AW-1:0] a, input logic eDefer, input string tag);
    step(0, 0, 0, 0, 1, a, !eDefer, eDefer, 0, 0, 0, tag);
  endtask

  // Monitor: pops one expectation per cycle and compares away from the edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        expect_t e, a;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        a.allow = evictAllow; a.defer = evictDefer; a.stall = leadStall;
        a.done = invDone; a.doneAddr = invDone ? invDoneAddr : '0;
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: got allow=%0b defer=%0b stall=%0b done=%0b addr=%h, expected allow=%0b defer=%0b stall=%0b done=%0b addr=%h",
                   t, a.allow, a.defer, a.stall, a.done, a.doneAddr,
                   e.allow, e.defer, e.stall, e.done, e.doneAddr);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, then any eviction allowed
    idle(0, 0, "R1 idle after reset");
    evict(12'h010, 0, "R1 evict empty");
    // R2, R5, R6: single load, deferral, completion pulse
    lead(12'h010, 0, "R2 first load accepted");
    evict(12'h010, 1, "R5 evict deferred");
    idle(0, 0, "R6 no pulse while outstanding");
    trail(12'h010, "R6 retire to zero");
    idle(1, 12'h010, "R6 pulse after retire");
    evict(12'h010, 0, "R6 pulse one cycle, entry freed");
    // R3: three loads need three retires
    lead(12'h020, 0, "R3 load 1");
    lead(12'h020, 0, "R3 load 2");
    lead(12'h020, 0, "R3 load 3");
    evict(12'h020, 1, "R3 deferred at count 3");
    trail(12'h020, "R3 retire 1");
    trail(12'h020, "R3 retire 2");
    evict(12'h020, 1, "R3 still deferred at count 1");
    trail(12'h020, "R3 retire 3");
    idle(1, 12'h020, "R3 pulse after last retire");
    // R11: retire to unknown address has no effect
    trail(12'h030, "R11 stray retire");
    idle(0, 0, "R11 no pulse from stray retire");
    evict(12'h030, 0, "R11 untracked still allowed");
    // R4: no request gives neither answer (covered by idle steps), zero count allows
    evict(12'h020, 0, "R4 drained address allowed");
    // R9: simultaneous hit and retire leaves count at one
    lead(12'h040, 0, "R9 load");
    step(1, 12'h040, 1, 12'h040, 0, 0, 0, 0, 0, 0, 0, "R9 load and retire together");
    evict(12'h040, 1, "R9 count unchanged, deferred");
    trail(12'h040, "R9 retire");
    idle(1, 12'h040, "R9 pulse proves count was one");
    // R10: saturation at count 3 stalls
    lead(12'h050, 0, "R10 load 1");
    lead(12'h050, 0, "R10 load 2");
    lead(12'h050, 0, "R10 load 3");
    lead(12'h050, 1, "R10 load at max stalls");
    trail(12'h050, "R10 retire 1");
    trail(12'h050, "R10 retire 2");
    evict(12'h050, 1, "R10 count stayed 3, deferred");
    trail(12'h050, "R10 retire 3");
    idle(1, 12'h050, "R10 pulse");
    // R7, R12: full buffer
    lead(12'h101, 0, "R7 fill 1");
    lead(12'h102, 0, "R7 fill 2");
    lead(12'h103, 0, "R7 fill 3");
    lead(12'h104, 0, "R7 fill 4");
    lead(12'h105, 1, "R7 new address stalls when full");
    lead(12'h101, 0, "R7 hit accepted when full");
    evict(12'h105, 0, "R7 stalled load not recorded");
    trail(12'h101, "R12 retire 1");
    trail(12'h101, "R12 retire 2");
    evict(12'h101, 0, "R12 single entry drained");
    // R8: freed entry reused
    lead(12'h105, 0, "R8 reuse freed entry");
    evict(12'h105, 1, "R8 reused entry deferred");
    trail(12'h105, "R8 retire");
    idle(1, 12'h105, "R8 pulse from reused entry");
    idle(0, 0, "R6 pulse gone");
    @(negedge clk);
    #2;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule